// File: doc/BRIEF.md
# Parallel display bus write engine

This block turns a stream of byte requests into write cycles on an 8-bit, write-only parallel bus of the 8080 kind, as used by small display controllers. Each request carries one byte and a flag saying whether the byte is a command or pixel/parameter data. The flag drives the register-select pin for the whole access, much as an address line would. The block owns the register-select, write-strobe, read-strobe and data pins. Chip select is left to the sequencer above it.

Every access runs through a fixed-count sequence. First comes an address-setup phase, in which the write strobe stays high while data and register-select are already valid. Next comes a strobe phase with the write strobe low. Last comes one hold cycle after the strobe rises. Both phase lengths are parameters counted in system clocks. No wait or ready input from the panel is sampled. The upstream port is valid/ready. Ready is high only while the engine is idle, so a byte is taken only after the previous write has finished completely.

The controller states are IDLE (ready high, waiting), SETUP (strobe high, bus driven), STROBE (strobe low) and HOLD (strobe high, bus held). The transitions are IDLE to SETUP on an accepted request, SETUP to STROBE when the setup count expires, STROBE to HOLD when the strobe count expires, and HOLD to IDLE unconditionally. IDLE stays in IDLE while no request is valid.

Top module: `pbus_wr_engine`

## Requirements
- R1: After reset the write strobe and the read strobe are high, ready is high, register-select is low and the data bus is 0x00.
- R2: Ready is high only in IDLE. After a request is accepted, ready stays low for exactly S+W+1 cycles, where S and W are the effective setup and strobe lengths. It then returns high.
- R3: In the cycle after acceptance, the data bus shows the request byte and register-select shows the flag (0 = command, 1 = data).
- R4: After acceptance the write strobe stays high for exactly S cycles (the setup phase) before it falls.
- R5: The write strobe is low for exactly W consecutive cycles per access.
- R6: Data and register-select do not change while the strobe is low, nor in the cycle after it rises.
- R7: A setup or strobe parameter of 0 behaves as 1.
- R8: The read strobe is high in every cycle.
- R9: A request presented while ready is low is ignored. The bus keeps the byte and flag of the access in progress, and no extra strobe is produced.
- R10: A request held valid across an access is accepted in the first IDLE cycle. Its byte appears on the bus in the next cycle, with no turnaround beyond the hold and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | High when a request can be accepted (IDLE) |
| req_is_data | input | 1 | 0 = command byte, 1 = data byte |
| req_byte | input | BUS_W | Byte to write |
| bus_db | output | BUS_W | Parallel data bus |
| bus_rs | output | 1 | Register-select (low command, high data) |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, always high |

## Verification
The bench builds two copies of the engine. The first uses setup 2 and strobe 3, which keeps each access down to seven cycles. That length allows a sweep of all 256 byte values with both flag settings, and each cycle of every access is compared with arithmetically predicted strobe, ready and bus values. The second copy uses setup and strobe both 0. This brings the clamp-to-one rule within reach and exercises the shortest possible access.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } pbus_state_e;

    // A phase length of zero is raised to one cycle.
    function automatic int eff_count(input int raw);
        return (raw < 1) ? 1 : raw;
    endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
`timescale 1ns/1ps
module pbus_phase_timer #(
    parameter int SETUP_EFF  = 7,
    parameter int STROBE_EFF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_setup,
    input  logic load_strobe,
    output logic done
);
    localparam int MAXC = (SETUP_EFF > STROBE_EFF) ? SETUP_EFF : STROBE_EFF;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_setup) begin
            cnt_q <= CW'(SETUP_EFF - 1);
        end else if (load_strobe) begin
            cnt_q <= CW'(STROBE_EFF - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pbus_ctrl_fsm.sv
`timescale 1ns/1ps
module pbus_ctrl_fsm
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        tmr_done,
    output pbus_state_e state_q,
    output pbus_state_e state_d,
    output logic        accept,
    output logic        load_setup,
    output logic        load_strobe,
    output logic        req_ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        load_setup  = 1'b0;
        load_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d    = ST_SETUP;
                    load_setup = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    state_d     = ST_STROBE;
                    load_strobe = 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

endmodule

// File: rtl/pbus_pin_drv.sv
`timescale 1ns/1ps
module pbus_pin_drv
    import pbus_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BUS_W-1:0] req_byte,
    input  logic             req_is_data,
    input  pbus_state_e      state_d,
    output logic [BUS_W-1:0] bus_db,
    output logic             bus_rs,
    output logic             bus_wr_n,
    output logic             bus_rd_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_db   <= '0;
            bus_rs   <= 1'b0;
            bus_wr_n <= 1'b1;
        end else begin
            if (accept) begin
                bus_db <= req_byte;
                bus_rs <= req_is_data;
            end
            bus_wr_n <= (state_d != ST_STROBE);
        end
    end

    assign bus_rd_n = 1'b1;

endmodule

// File: rtl/pbus_wr_engine.sv
`timescale 1ns/1ps
module pbus_wr_engine
    import pbus_pkg::*;
#(
    parameter int BUS_W      = 8,
    parameter int SETUP_CYC  = 7,
    parameter int STROBE_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_data,
    input  logic [BUS_W-1:0] req_byte,
    output logic [BUS_W-1:0] bus_db,
    output logic             bus_rs,
    output logic             bus_wr_n,
    output logic             bus_rd_n
);
    localparam int SETUP_EFF  = eff_count(SETUP_CYC);
    localparam int STROBE_EFF = eff_count(STROBE_CYC);

    pbus_state_e state_q;
    pbus_state_e state_d;
    logic        accept;
    logic        load_setup;
    logic        load_strobe;
    logic        tmr_done;

    pbus_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .tmr_done    (tmr_done),
        .state_q     (state_q),
        .state_d     (state_d),
        .accept      (accept),
        .load_setup  (load_setup),
        .load_strobe (load_strobe),
        .req_ready   (req_ready)
    );

    pbus_phase_timer #(
        .SETUP_EFF  (SETUP_EFF),
        .STROBE_EFF (STROBE_EFF)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_setup  (load_setup),
        .load_strobe (load_strobe),
        .done        (tmr_done)
    );

    pbus_pin_drv #(
        .BUS_W (BUS_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_byte    (req_byte),
        .req_is_data (req_is_data),
        .state_d     (state_d),
        .bus_db      (bus_db),
        .bus_rs      (bus_rs),
        .bus_wr_n    (bus_wr_n),
        .bus_rd_n    (bus_rd_n)
    );

endmodule

// File: rtl/pbus_wr_engine_chk.sv
`timescale 1ns/1ps
module pbus_wr_engine_chk #(
    parameter int BUS_W      = 8,
    parameter int STROBE_EFF = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BUS_W-1:0] bus_db,
    input logic             bus_rs,
    input logic             bus_wr_n,
    input logic             bus_rd_n
);
    logic [15:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (bus_wr_n) begin
            low_cnt_q <= '0;
        end else begin
            low_cnt_q <= low_cnt_q + 16'd1;
        end
    end

    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n);

    p_ready_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_wr_n);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (low_cnt_q == 16'(STROBE_EFF)));

    p_stable_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |=> ($stable(bus_db) && $stable(bus_rs)));

    p_hold_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |=> ($stable(bus_db) && $stable(bus_rs)));

    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(bus_db) && $stable(bus_rs)));

endmodule

bind pbus_wr_engine pbus_wr_engine_chk #(
    .BUS_W      (BUS_W),
    .STROBE_EFF (pbus_pkg::eff_count(STROBE_CYC))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_db    (bus_db),
    .bus_rs    (bus_rs),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n)
);

// File: tb/test_pbus_wr_engine.sv
`timescale 1ns/1ps
module test_pbus_wr_engine;
    localparam int SA = 2;
    localparam int WA = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       va, fa, rdya, rsa, wra, rda;
    logic [7:0] ba, dba;
    logic       vb, fb, rdyb, rsb, wrb, rdb;
    logic [7:0] bb, dbb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    pbus_wr_engine #(.BUS_W(8), .SETUP_CYC(SA), .STROBE_CYC(WA)) i_pbus_wr_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(rdya),
        .req_is_data(fa), .req_byte(ba), .bus_db(dba), .bus_rs(rsa),
        .bus_wr_n(wra), .bus_rd_n(rda));

    pbus_wr_engine #(.BUS_W(8), .SETUP_CYC(0), .STROBE_CYC(0)) i_pbus_wr_engine_min (
        .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rdyb),
        .req_is_data(fb), .req_byte(bb), .bus_db(dbb), .bus_rs(rsb),
        .bus_wr_n(wrb), .bus_rd_n(rdb));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic o_rdy(input bit s);  return s ? rdyb : rdya; endfunction
    function automatic logic o_wr(input bit s);   return s ? wrb : wra;   endfunction
    function automatic logic o_rs(input bit s);   return s ? rsb : rsa;   endfunction
    function automatic logic o_rd(input bit s);   return s ? rdb : rda;   endfunction
    function automatic logic [7:0] o_db(input bit s); return s ? dbb : dba; endfunction

    task automatic drive(input bit s, input logic v, input logic f, input logic [7:0] b);
        if (s) begin vb = v; fb = f; bb = b; end
        else   begin va = v; fa = f; ba = b; end
    endtask

    // One complete access; the byte is swapped for junk while busy (R9).
    task automatic one_write(input bit s, input int st, input int wt,
                             input logic f, input logic [7:0] b);
        string tag;
        @(negedge clk);
        drive(s, 1'b1, f, b);
        chk(o_rdy(s) == 1'b1, "R2 ready in idle", o_rdy(s), 1);
        for (int i = 1; i <= st + wt + 2; i++) begin
            @(negedge clk);
            if (i == 1) drive(s, 1'b1, ~f, ~b);
            if (i == st + wt + 1) drive(s, 1'b0, f, b);
            tag = s ? "R7" : (i <= st ? "R4" : (i <= st + wt ? "R5" : "R6"));
            chk(o_wr(s) == !(i > st && i <= st + wt), tag, o_wr(s), !(i > st && i <= st + wt));
            chk(o_rdy(s) == (i == st + wt + 2), "R2 ready timing", o_rdy(s), (i == st + wt + 2));
            chk(o_db(s) == b, (i == 1) ? "R3 data" : "R9 data held", o_db(s), b);
            chk(o_rs(s) == f, (i == 1) ? "R3 select" : "R6 select held", o_rs(s), f);
            chk(o_rd(s) == 1'b1, "R8 read strobe", o_rd(s), 1);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        drive(1'b1, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(wra == 1'b1, "R1 wr_n", wra, 1);
        chk(rda == 1'b1, "R1 rd_n", rda, 1);
        chk(dba == 8'h00, "R1 db", dba, 0);
        chk(rsa == 1'b0, "R1 rs", rsa, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdya == 1'b1, "R1 ready", rdya, 1);
        chk(wrb == 1'b1, "R1 wr_n min", wrb, 1);

        // Sweep every byte value with both flag settings.
        for (int v = 0; v < 512; v++) begin
            one_write(1'b0, SA, WA, v[0], v[8:1]);
        end

        // R7: zero parameters act as one.
        for (int v = 0; v < 16; v++) begin
            one_write(1'b1, 1, 1, v[0], 8'(v * 17));
        end

        // R10: request held valid across an access.
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 8'h3C);
        for (int i = 1; i <= SA + WA + 2; i++) begin
            @(negedge clk);
            if (i == 1) drive(1'b0, 1'b1, 1'b1, 8'hC3);
        end
        chk(rdya == 1'b1, "R10 idle reached", rdya, 1);
        chk(dba == 8'h3C, "R10 old byte kept", dba, 8'h3C);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        chk(rdya == 1'b0, "R10 accepted", rdya, 0);
        chk(dba == 8'hC3, "R10 next byte", dba, 8'hC3);
        chk(rsa == 1'b1, "R10 next select", rsa, 1);
        chk(wra == 1'b1, "R10 setup first", wra, 1);
        repeat (SA + WA + 2) @(negedge clk);
        chk(rdya == 1'b1, "R10 done", rdya, 1);

        // R9: with no request, nothing moves.
        repeat (5) @(negedge clk);
        chk(wra == 1'b1 && dba == 8'hC3, "R9 quiet bus", {wra, dba}, {1'b1, 8'hC3});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule